// File: doc/BRIEF.md
# Debounced status interrupt controller

This block collects three status sources from a charger-detection front end and turns them into one interrupt request. The sources are the analog bus-voltage comparator, the dead-battery-mode flag and the contact-detection timeout flag. The comparator output is raw and asynchronous, so it is synchronized and then debounced. A new level is accepted only after it has held for a programmable number of clock ticks. Any accepted comparator change, in either direction, latches a pending event. The two flags latch a pending event only when they rise.

Pending events stay latched until software reads the interrupt register. A global enable input masks the interrupt line. While it is low, the pending bits are kept, and they drive the line again as soon as the enable returns. The interrupt line is active-low and open-drain. It is modelled here as an output-enable signal, where 1 means the pad pulls the line low. A charger-detection busy indication can be read in the register, but it never causes an interrupt.

Top module: `stat_irq_ctrl`

## Requirements
- R1: A level change on `vbus_cmp_i` that first drives before clock edge e0 and then holds is accepted after `DB_TICKS` synchronized samples. Its pending bit (bit 0) becomes visible after edge e0+DB_TICKS+2, and not before.
- R2: A comparator level that holds for fewer than `DB_TICKS` cycles is never accepted. A return to the old level during the window restarts the count, so a series of short pulses never sets bit 0.
- R3: An accepted comparator change sets bit 0 whether the debounced level rises or falls.
- R4: A 0-to-1 transition of `dead_batt_i` sets pending bit 1, and one of `dcd_tmo_i` sets pending bit 2, after the first edge that samples the high level. A 1-to-0 transition of either flag sets nothing.
- R5: `irq_oe_o` is 1 exactly when `irq_en_i` is 1 and at least one pending bit is set. It follows combinationally from the pending state and the enable.
- R6: While `irq_en_i` is 0, `irq_oe_o` is 0 and the pending bits are kept. Setting `irq_en_i` back to 1 drives `irq_oe_o` again without any new event.
- R7: A strobe with `rd_addr_i` = 0x02 loads `rd_data_o` at that edge with {busy, dcd flag, dead-battery flag, debounced comparator, 0, pending[2:0]} (bit 7 down to bit 0), and clears every pending bit. A strobe at any other address loads 0 and clears nothing.
- R8: An event that occurs on the same edge as a clearing read is not in that read's data, but it stays pending.
- R9: `det_busy_i` never sets a pending bit in either direction.
- R10: After reset, the pending bits, the debounced level, `rd_data_o` and `irq_oe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vbus_cmp_i | input | 1 | Raw bus-voltage comparator output |
| dead_batt_i | input | 1 | Dead-battery-mode flag |
| dcd_tmo_i | input | 1 | Data-contact-detection timeout flag |
| det_busy_i | input | 1 | Charger detection running (status only) |
| irq_en_i | input | 1 | Global interrupt enable |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register address of the read |
| rd_data_o | output | 8 | Read data, valid after the strobe edge |
| irq_oe_o | output | 1 | Interrupt pull-down enable (1 = line low) |

## Verification
A comparator change driven before edge e0 reaches the interrupt line after edge e0+DB_TICKS+2. This delay is made of two synchronizer stages, the tick window and one edge-detect stage. The bench samples on falling edges and checks the line one sample before that edge and one sample after it. A flag rise appears after its first sampling edge. Read data is due on the edge that takes the strobe, and the pending bits clear on that same edge. The bench therefore samples read data and the line at the falling edge right after the strobe. Pulse-length sweeps run up to DB_TICKS-1 and at DB_TICKS to test the acceptance boundary. An all-patterns sweep over the pending bits and the enable checks the mask.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_VB  = 0;
  localparam int SRC_DB  = 1;
  localparam int SRC_DCD = 2;
  localparam int RD_W    = 8;
  localparam logic [7:0] IRQ_REG_ADDR = 8'h02;
  // 1 = event on rising edge only, 0 = event on any change
  localparam logic [NSRC-1:0] RISE_ONLY = 3'b110;
endpackage

// File: rtl/sirq_debounce.sv
module sirq_debounce #(
  parameter int TICKS = 3750000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o,
  output logic stable_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LIM = CW'(TICKS - 1);

  logic s1, s2, stab;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      stab <= 1'b0;
      cnt  <= '0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 != stab) begin
        if (cnt == LIM) begin
          stab <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0; // bounce restarts the window
      end
    end
  end

  assign sync_o   = s2;
  assign stable_o = stab;
endmodule

// File: rtl/sirq_edge.sv
module sirq_edge #(
  parameter int N = 3,
  parameter logic [N-1:0] RISE_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_det
    if (RISE_MASK[g]) begin : g_rise
      assign evt_o[g] = lvl_i[g] & ~lvl_q[g];
    end else begin : g_any
      assign evt_o[g] = lvl_i[g] ^ lvl_q[g];
    end
  end
endmodule

// File: rtl/sirq_pend.sv
module sirq_pend #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~{N{clr_i}}) | set_i; // set wins over clear
  end
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int DB_TICKS = 3750000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vbus_cmp_i,
  input  logic            dead_batt_i,
  input  logic            dcd_tmo_i,
  input  logic            det_busy_i,
  input  logic            irq_en_i,
  input  logic            rd_stb_i,
  input  logic [7:0]      rd_addr_i,
  output logic [RD_W-1:0] rd_data_o,
  output logic            irq_oe_o
);
  logic            vb_sync, vb_stable;
  logic [NSRC-1:0] lvl, evt, pend;
  logic            rd_hit;

  sirq_debounce #(.TICKS(DB_TICKS)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (vbus_cmp_i),
    .sync_o  (vb_sync),
    .stable_o(vb_stable)
  );

  always_comb begin
    lvl          = '0;
    lvl[SRC_VB]  = vb_stable;
    lvl[SRC_DB]  = dead_batt_i;
    lvl[SRC_DCD] = dcd_tmo_i;
  end

  sirq_edge #(.N(NSRC), .RISE_MASK(RISE_ONLY)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .evt_o (evt)
  );

  assign rd_hit = rd_stb_i && (rd_addr_i == IRQ_REG_ADDR);

  sirq_pend #(.N(NSRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt),
    .clr_i (rd_hit),
    .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (rd_stb_i)
      rd_data_o <= rd_hit ? {det_busy_i, dcd_tmo_i, dead_batt_i, vb_stable, 1'b0, pend} : '0;
  end

  assign irq_oe_o = irq_en_i & (|pend);
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_en_i,
  input logic       dead_batt_i,
  input logic       dcd_tmo_i,
  input logic       rd_hit,
  input logic       vb_sync,
  input logic       vb_stable,
  input logic [2:0] pend
);
  assert_stable_from_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vb_stable != $past(vb_stable)) |-> (vb_stable == $past(vb_sync)));

  assert_vb_change_pends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vb_stable != $past(vb_stable)) |=> pend[0]);

  assert_db_rise_pends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dead_batt_i) |=> pend[1]);

  assert_dcd_rise_pends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dcd_tmo_i) |=> pend[2]);

  assert_mask_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && (pend != 3'b000) && !rd_hit) |=> (pend != 3'b000));

  assert_clear_only_by_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend) & ~pend) != 3'b000 |-> $past(rd_hit));
endmodule

bind stat_irq_ctrl sirq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_en_i   (irq_en_i),
  .dead_batt_i(dead_batt_i),
  .dcd_tmo_i  (dcd_tmo_i),
  .rd_hit     (rd_hit),
  .vb_sync    (vb_sync),
  .vb_stable  (vb_stable),
  .pend       (pend)
);

// File: tb/stat_irq_ctrl_tb.sv
module stat_irq_ctrl_tb;
  localparam int DB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vb = 1'b0, db = 1'b0, dcd = 1'b0, busy = 1'b0, en = 1'b0, stb = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  stat_irq_ctrl #(.DB_TICKS(DB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vbus_cmp_i(vb), .dead_batt_i(db),
    .dcd_tmo_i(dcd), .det_busy_i(busy), .irq_en_i(en), .rd_stb_i(stb),
    .rd_addr_i(addr), .rd_data_o(rdata), .irq_oe_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] stat(input logic vbs);
    return {busy, dcd, db, vbs, 4'b0000};
  endfunction

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    d = rdata;
  endtask

  logic [7:0] d;
  logic       vbs = 1'b0;

  initial begin
    cyc(2);
    chk("R10 rdata", rdata, 8'h00);
    chk("R10 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    rd(8'h02, d); chk("R10 pend", d, 8'h00);
    en = 1'b1;

    // R1/R3 exact latency, both directions
    for (int dir = 0; dir < 2; dir++) begin
      vb = (dir == 0);
      cyc(DB + 2);
      chk("R1 early", {7'd0, irq}, 8'h00);
      cyc(1);
      chk("R1 due", {7'd0, irq}, 8'h01);
      vbs = vb;
      rd(8'h02, d); chk("R3 read", d, stat(vbs) | 8'h01);
      chk("R7 cleared", {7'd0, irq}, 8'h00);
    end

    // R2 short pulses below the window
    for (int len = 1; len < DB; len++) begin
      vb = 1'b1; cyc(len); vb = 1'b0; cyc(DB + 4);
      chk("R2 short pulse", {7'd0, irq}, 8'h00);
    end
    // R2 restart: pulses separated by one-cycle gaps
    for (int k = 0; k < 4; k++) begin
      vb = 1'b1; cyc(DB - 1); vb = 1'b0; cyc(1);
    end
    cyc(DB + 4);
    chk("R2 restart", {7'd0, irq}, 8'h00);
    rd(8'h02, d); chk("R2 none", d, 8'h00);
    // R2 boundary: exactly DB cycles accepted
    vb = 1'b1; cyc(DB); vb = 1'b0; cyc(DB + 4);
    chk("R2 boundary", {7'd0, irq}, 8'h01);
    rd(8'h02, d); chk("R2 boundary read", d, 8'h01);

    // R4 flags
    db = 1'b1; cyc(1);
    chk("R4 db rise", {7'd0, irq}, 8'h01);
    rd(8'h02, d); chk("R4 db read", d, 8'h22);
    db = 1'b0; cyc(3);
    chk("R4 db fall", {7'd0, irq}, 8'h00);
    dcd = 1'b1; cyc(1);
    chk("R4 dcd rise", {7'd0, irq}, 8'h01);
    rd(8'h02, d); chk("R4 dcd read", d, 8'h44);
    dcd = 1'b0; cyc(3);
    chk("R4 dcd fall", {7'd0, irq}, 8'h00);

    // R9 busy
    busy = 1'b1; cyc(3); busy = 1'b0; cyc(3); busy = 1'b1; cyc(2);
    chk("R9 busy irq", {7'd0, irq}, 8'h00);
    rd(8'h02, d); chk("R9 busy read", d, 8'h80);
    busy = 1'b0;

    // R5/R6 sweep over every pending pattern and enable
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 8; p++) begin
        en = e[0];
        if (p[0]) begin vb = ~vb; vbs = vb; cyc(DB + 4); end
        db = p[1]; dcd = p[2]; cyc(1); db = 1'b0; dcd = 1'b0; cyc(1);
        chk("R5 masked/enabled", {7'd0, irq}, {7'd0, e[0] && (p != 0)});
        en = 1'b1; cyc(1);
        chk("R6 re-enable", {7'd0, irq}, {7'd0, p != 0});
        rd(8'h02, d); chk("R7 sweep read", d, stat(vbs) | 8'(p));
      end
    end

    // R8 event on the clearing edge
    addr = 8'h02; stb = 1'b1; db = 1'b1;
    @(negedge clk); stb = 1'b0; d = rdata;
    chk("R8 snapshot", d, 8'h20 | stat(vbs));
    chk("R8 kept", {7'd0, irq}, 8'h01);
    rd(8'h02, d); chk("R8 later read", d, 8'h22 | stat(vbs));
    db = 1'b0; cyc(1);

    // R7 other address
    dcd = 1'b1; cyc(1); dcd = 1'b0; cyc(1);
    rd(8'h01, d); chk("R7 other addr data", d, 8'h00);
    chk("R7 other addr keeps", {7'd0, irq}, 8'h01);
    rd(8'h02, d); chk("R7 after other", d, 8'h04 | stat(vbs));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule